// File: doc/BRIEF.md
# Clockless Power-Down Status Register

This block is the one host-visible register of a link controller that stays usable while the link's system clock is stopped. It is clocked by the host interface clock, which keeps running when the PHY withholds the system clock. The host reaches it with the same chip-select and write-strobe handshake as the other base registers. A write takes effect on the next host clock edge. A read is a purely combinational view of the register, with no shadow-register transfer.

The register word mixes four kinds of bit:
- Mirrored status bits: the gated link power request going to the PHY, and a clock-off indicator. The clock-off indicator comes from a small monitor that watches a toggle flop running on the system clock.
- Sticky event flags: three of them, each cleared by writing 1 to its position.
- Interrupt enables: four, one for the clock-off indicator and one for each event flag.
- A software power-down control: together with an external power-down pin, it gates the power request toward the PHY.

A single level-sensitive interrupt output collects the enabled sources.

Top module: `pwrdn_status_reg`

## Requirements
- R1: After reset, the event flags (bits 4:2), the software power-down bit (bit 5) and the enables (bits 11:8) read 0, and irq_o is 0.
- R2: Bit 0 of the read word equals lps_o at all times, with no clock edge needed. A dip of the power request is visible while it lasts.
- R3: lps_o is 1 only when lps_req_i is 1, software power-down (bit 5) is 0 and pd_pin_i is 0. Bit 5 reads back the written value and never the pin state.
- R4: Bit 1 (clock off) reads 1 once sys_clk has been still for more than CLK_TIMEOUT host cycles. It reads 0 within a few host cycles after sys_clk runs again.
- R5: An event input that is high at a host clock edge sets its flag: ev_i[0] sets bit 2, ev_i[1] sets bit 3 and ev_i[2] sets bit 4. The flag stays 1 after the input falls.
- R6: Writing 1 to a flag position clears that flag whether or not its enable is set. Writing 0 leaves the flag unchanged.
- R7: A clear written in the same cycle as an active event input leaves the flag at 1.
- R8: irq_o is the OR of each event flag ANDed with its enable. Bit 9 enables bit 2, bit 10 enables bit 3 and bit 11 enables bit 4. A set flag whose enable is 0 does not raise irq_o.
- R9: With bit 8 set and the clock off, irq_o is 1. Writing 1 to bit 1 acknowledges this and drops irq_o while bit 1 still reads 1. The acknowledge is forgotten once the clock runs again.
- R10: Writes to bits 11:8 and bit 5 are readable at the next sample. Bits 7:6 and 15:12 always read 0, and host_rdata is 0 while host_cs is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host interface clock, always running |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sys_clk | input | 1 | Link system clock, may be stopped |
| host_cs | input | 1 | Register select strobe |
| host_we | input | 1 | Write strobe, qualified by host_cs |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Combinational read data |
| lps_req_i | input | 1 | Link core's power request before gating |
| pd_pin_i | input | 1 | External power-down pin, active high |
| ev_i | input | 3 | Continuous event conditions (PHY interrupt, arbitration loss, clock activity) |
| lps_o | output | 1 | Gated power request to the PHY |
| irq_o | output | 1 | Level interrupt |

## Verification
Event flags are driven with these patterns:
- A single pulse, which separates sticky from mirrored behaviour.
- A condition held through a write-one clear, which separates "set wins" from "clear wins".
- A clear with the enable off, which shows that clearing does not depend on the enable.

The gating path is exercised with software power-down and the pin each applied alone and then together. This shows that the bit and the pin are independent. The system clock is stopped and restarted around an acknowledge. This tells a one-shot acknowledge apart from one that is never re-armed.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  localparam int NUM_EV      = 3;
  localparam int REG_W       = 16;
  localparam int B_LPWR      = 0;
  localparam int B_CLKOFF    = 1;
  localparam int B_EV0       = 2;
  localparam int B_SWPD      = B_EV0 + NUM_EV;
  localparam int B_EN0       = 8;              // enable of clock-off source
  localparam int B_EN_EV0    = B_EN0 + 1;      // enables of event flags follow
  localparam int NUM_EN      = NUM_EV + 1;

  function automatic logic [REG_W-1:0] used_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[B_LPWR]   = 1'b1;
    m[B_CLKOFF] = 1'b1;
    m[B_SWPD]   = 1'b1;
    for (int i = 0; i < NUM_EV; i++) m[B_EV0+i] = 1'b1;
    for (int i = 0; i < NUM_EN; i++) m[B_EN0+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pdr_reset_sync.sv
module pdr_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pdr_clk_monitor.sv
module pdr_clk_monitor #(
  parameter int TIMEOUT = 8,
  parameter int SYNC_STAGES = 3
) (
  input  logic host_clk,
  input  logic rst_n,        // synchronised host-domain reset
  input  logic rst_n_raw,    // async reset for the system-clock flop
  input  logic sys_clk,
  output logic sclk_active
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT);

  logic                   tgl_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   edge_seen;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       cnt_d;
  logic                   cnt_en;

  // toggle flop in the system-clock domain
  always_ff @(posedge sys_clk or negedge rst_n_raw) begin
    if (!rst_n_raw) tgl_q <= 1'b0;
    else            tgl_q <= ~tgl_q;
  end

  always_comb sync_d = {sync_q[SYNC_STAGES-2:0], tgl_q};

  always_ff @(posedge host_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign edge_seen = sync_q[SYNC_STAGES-1] ^ sync_q[SYNC_STAGES-2];

  always_comb begin
    cnt_en = edge_seen || (cnt_q != CNT_MAX);
    cnt_d  = edge_seen ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge host_clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_MAX;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign sclk_active = (cnt_q != CNT_MAX);

  // R4: a detected system-clock edge marks the clock active next cycle
  a_r4_edge_wakes: assert property (@(posedge host_clk) disable iff (!rst_n)
    edge_seen |=> sclk_active);
endmodule

// File: rtl/pdr_sticky_bit.sv
module pdr_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  // set dominates a simultaneous clear so no event is lost
  always_comb q_d = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/pwrdn_status_reg.sv
module pwrdn_status_reg #(
  parameter int CLK_TIMEOUT = 8,
  parameter int DATA_W      = pdr_pkg::REG_W,
  parameter int EV_N        = pdr_pkg::NUM_EV
) (
  input  logic              host_clk,
  input  logic              rst_n,
  input  logic              sys_clk,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              lps_req_i,
  input  logic              pd_pin_i,
  input  logic [EV_N-1:0]   ev_i,
  output logic              lps_o,
  output logic              irq_o
);
  import pdr_pkg::*;

  localparam int EN_N = EV_N + 1;
  localparam logic [DATA_W-1:0] USED = used_mask();

  logic              rst_n_s;
  logic              sclk_active;
  logic              clk_off;
  logic              wr_en;
  logic [EV_N-1:0]   ev_clr;
  logic [EV_N-1:0]   ev_q;
  logic              swpd_q, swpd_d;
  logic [EN_N-1:0]   en_q, en_d;
  logic              ack_q, ack_d;
  logic              ci_src;
  logic              ev_src;
  logic [DATA_W-1:0] view;
  logic              unused_wdata;

  pdr_reset_sync #(.STAGES(2)) i_rst_sync (
    .clk        (host_clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pdr_clk_monitor #(.TIMEOUT(CLK_TIMEOUT), .SYNC_STAGES(3)) i_clk_mon (
    .host_clk    (host_clk),
    .rst_n       (rst_n_s),
    .rst_n_raw   (rst_n),
    .sys_clk     (sys_clk),
    .sclk_active (sclk_active)
  );

  assign clk_off = ~sclk_active;
  assign wr_en   = host_cs & host_we;
  assign unused_wdata = ^(host_wdata & ~USED);

  // event flags, one sticky cell each
  for (genvar g = 0; g < EV_N; g++) begin : g_ev
    assign ev_clr[g] = wr_en & host_wdata[B_EV0+g];
    pdr_sticky_bit i_flag (
      .clk   (host_clk),
      .rst_n (rst_n_s),
      .set_i (ev_i[g]),
      .clr_i (ev_clr[g]),
      .q_o   (ev_q[g])
    );
  end

  // control and enable next state
  always_comb begin
    swpd_d = swpd_q;
    en_d   = en_q;
    if (wr_en) begin
      swpd_d = host_wdata[B_SWPD];
      en_d   = host_wdata[B_EN0 +: EN_N];
    end
    // clock-off acknowledge: armed by a write of 1, dropped when clock returns
    if (sclk_active) ack_d = 1'b0;
    else             ack_d = ack_q | (wr_en & host_wdata[B_CLKOFF]);
  end

  always_ff @(posedge host_clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      swpd_q <= 1'b0;
      en_q   <= '0;
      ack_q  <= 1'b0;
    end else begin
      swpd_q <= swpd_d;
      en_q   <= en_d;
      ack_q  <= ack_d;
    end
  end

  // power request gating toward the PHY
  assign lps_o = lps_req_i & ~swpd_q & ~pd_pin_i;

  // interrupt collection
  assign ci_src = en_q[0] & clk_off & ~ack_q;
  assign ev_src = |(ev_q & en_q[EN_N-1:1]);
  assign irq_o  = ci_src | ev_src;

  // combinational read view
  always_comb begin
    view                    = '0;
    view[B_LPWR]            = lps_o;
    view[B_CLKOFF]          = clk_off;
    view[B_EV0 +: EV_N]     = ev_q;
    view[B_SWPD]            = swpd_q;
    view[B_EN0 +: EN_N]     = en_q;
    host_rdata              = host_cs ? view : '0;
  end

  // R3: request never passes while either power-down source is active
  a_r3_gated: assert property (@(posedge host_clk) disable iff (!rst_n_s)
    lps_o |-> (!swpd_q && !pd_pin_i));
  // R8: any enabled, set flag drives the interrupt
  a_r8_irq_level: assert property (@(posedge host_clk) disable iff (!rst_n_s)
    (|(ev_q & en_q[EN_N-1:1])) |-> irq_o);
  // R9: acknowledge silences the clock-off source on the next cycle
  a_r9_ack: assert property (@(posedge host_clk) disable iff (!rst_n_s)
    (wr_en && host_wdata[B_CLKOFF] && clk_off) |=> !ci_src);
  // R10: write of control bits lands in the register
  a_r10_swpd_wr: assert property (@(posedge host_clk) disable iff (!rst_n_s)
    wr_en |=> (swpd_q == $past(host_wdata[B_SWPD])));
endmodule

// File: tb/test_pwrdn_status_reg.sv
module test_pwrdn_status_reg;
  logic        host_clk = 1'b0;
  logic        sys_clk  = 1'b0;
  logic        sys_run;
  logic        rst_n;
  logic        host_cs, host_we;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        lps_req_i, pd_pin_i;
  logic [2:0]  ev_i;
  logic        lps_o, irq_o;
  int          checks = 0;
  int          errors = 0;

  always #5 host_clk = ~host_clk;
  always #7 if (sys_run) sys_clk = ~sys_clk;

  pwrdn_status_reg i_pwrdn_status_reg (
    .host_clk, .rst_n, .sys_clk, .host_cs, .host_we, .host_wdata,
    .host_rdata, .lps_req_i, .pd_pin_i, .ev_i, .lps_o, .irq_o
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(output logic [15:0] v);
    host_cs = 1'b1; host_we = 1'b0;
    #1 v = host_rdata;
    host_cs = 1'b0;
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge host_clk);
    host_cs = 1'b1; host_we = 1'b1; host_wdata = d;
    @(negedge host_clk);
    host_cs = 1'b0; host_we = 1'b0; host_wdata = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rst_n = 1'b0;
    repeat (3) @(negedge host_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge host_clk);
    rd(v);
    chk("R1 stored bits", v & 16'h0F3C, 16'h0000);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    host_cs = 1'b0;
    #1 chk("R10 rdata idle", host_rdata, 16'h0000);
  endtask

  task automatic t_power();
    logic [15:0] v;
    @(negedge host_clk);
    lps_req_i = 1'b1;
    rd(v);
    chk("R3 lps passes", {15'd0, lps_o}, 16'd1);
    chk("R2 status mirrors", {15'd0, v[0]}, 16'd1);
    // dip without an intervening edge
    lps_req_i = 1'b0;
    rd(v);
    chk("R2 dip visible", {15'd0, v[0]}, 16'd0);
    lps_req_i = 1'b1;
    pd_pin_i = 1'b1;
    rd(v);
    chk("R3 pin gates", {14'd0, lps_o, v[0]}, 16'd0);
    chk("R3 swpd not pin", {15'd0, v[5]}, 16'd0);
    pd_pin_i = 1'b0;
    wr(16'h0020);
    rd(v);
    chk("R3 swpd gates", {14'd0, lps_o, v[0]}, 16'd0);
    chk("R10 swpd readback", v & 16'hF0C0, 16'h0000);
    chk("R10 swpd bit", {15'd0, v[5]}, 16'd1);
    wr(16'h0000);
    rd(v);
    chk("R3 released", {15'd0, lps_o}, 16'd1);
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    @(negedge host_clk);
    ev_i = 3'b101;
    @(negedge host_clk);
    ev_i = 3'b000;
    @(negedge host_clk);
    rd(v);
    chk("R5 flags held", v & 16'h001C, 16'h0014);
    wr(16'h0000);
    rd(v);
    chk("R6 write 0 keeps", v & 16'h001C, 16'h0014);
    wr(16'h0004);
    rd(v);
    chk("R6 w1c no enable", v & 16'h001C, 16'h0010);
    wr(16'h0010);
    rd(v);
    chk("R6 w1c second", v & 16'h001C, 16'h0000);
  endtask

  task automatic t_race();
    logic [15:0] v;
    @(negedge host_clk);
    ev_i = 3'b010;
    @(negedge host_clk);
    host_cs = 1'b1; host_we = 1'b1; host_wdata = 16'h0008;
    @(negedge host_clk);
    host_cs = 1'b0; host_we = 1'b0; host_wdata = '0;
    ev_i = 3'b000;
    rd(v);
    chk("R7 set wins", {15'd0, v[3]}, 16'd1);
    wr(16'h0008);
    rd(v);
    chk("R7 clear after", {15'd0, v[3]}, 16'd0);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    @(negedge host_clk);
    ev_i = 3'b010;
    @(negedge host_clk);
    ev_i = 3'b000;
    @(negedge host_clk);
    chk("R8 disabled no irq", {15'd0, irq_o}, 16'd0);
    wr(16'h0200);
    chk("R8 wrong enable", {15'd0, irq_o}, 16'd0);
    wr(16'h0400);
    chk("R8 enabled irq", {15'd0, irq_o}, 16'd1);
    rd(v);
    chk("R10 enable readback", v & 16'h0F00, 16'h0400);
    wr(16'h0408);
    chk("R8 ack drops irq", {15'd0, irq_o}, 16'd0);
    wr(16'h0000);
  endtask

  task automatic t_clock();
    logic [15:0] v;
    rd(v);
    chk("R4 running", {15'd0, v[1]}, 16'd0);
    wr(16'h0100);
    chk("R9 no irq while running", {15'd0, irq_o}, 16'd0);
    sys_run = 1'b0;
    repeat (20) @(negedge host_clk);
    rd(v);
    chk("R4 stopped", {15'd0, v[1]}, 16'd1);
    chk("R9 irq on stop", {15'd0, irq_o}, 16'd1);
    wr(16'h0102);
    rd(v);
    chk("R9 ack irq", {15'd0, irq_o}, 16'd0);
    chk("R9 still off", {15'd0, v[1]}, 16'd1);
    sys_run = 1'b1;
    repeat (10) @(negedge host_clk);
    rd(v);
    chk("R4 restarted", {15'd0, v[1]}, 16'd0);
    sys_run = 1'b0;
    repeat (20) @(negedge host_clk);
    chk("R9 rearmed", {15'd0, irq_o}, 16'd1);
    sys_run = 1'b1;
    repeat (10) @(negedge host_clk);
    wr(16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge host_clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sys_run = 1'b1; rst_n = 1'b0;
    host_cs = 1'b0; host_we = 1'b0; host_wdata = '0;
    lps_req_i = 1'b0; pd_pin_i = 1'b0; ev_i = '0;
    t_reset();
    t_power();
    t_sticky();
    t_race();
    t_irq();
    t_clock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule